// File: doc/BRIEF.md
# Per-CPU Interrupt Priority Dispatcher

This block handles interrupt delivery to a single processor inside a larger multi-source interrupt controller. It keeps two bit vectors over all sources. The raised vector holds requests that wait for the processor. The in-service vector holds requests that the processor has taken and not yet retired. Each source's priority, vector number, sense mode and activity bit are inputs from the controller's configuration storage. In return, the block issues one-cycle strobes that set or clear a source's activity (and pending) state.

The controller offers a source with `raise_valid` and `raise_id`. The block accepts the request only when the source's priority is above the processor's task priority and the source is not already raised. An accepted request drives the interrupt line. The processor uses a small register window to program task priority, read its own identity, acknowledge the highest raised source and signal end of interrupt. An acknowledge re-checks the source before handing out its vector and returns a spurious vector if the check fails. An end of interrupt retires the top in-service source and may re-assert the line for a queued request.

Top module: `cpu_irq_dispatch`

## Requirements
- R1: When several sources are raised, an acknowledge selects the one with the highest 4-bit priority. On equal priority the lowest-numbered source wins.
- R2: A raise request whose source priority is less than or equal to the task priority is dropped. It produces no activity-set strobe and leaves the interrupt line and the raised vector unchanged.
- R3: A raise request for a source that is already in the raised vector is dropped as a missed interrupt, with no activity-set strobe.
- R4: The task priority resets to 15. A write to offset 0x80 stores only bits 3:0. A read of 0x80 returns the value zero-extended.
- R5: An accepted raise pulses `act_set` for that source in the same cycle, and `irq_out` is high in the following cycle.
- R6: An acknowledge read (offset 0xA0) drives `irq_out` low in the following cycle. With nothing raised it returns the spurious vector and pulses no strobe.
- R7: On acknowledge, the selected source is checked. If its activity bit is clear or its priority is no longer above the task priority, its activity is cleared and the spurious vector is returned. Otherwise the source enters the in-service vector and its own 8-bit vector is returned.
- R8: An acknowledge always removes the selected source from the raised vector. An edge-sensitive selected source (sense bit 0) also gets an `act_clr` strobe.
- R9: A write to offset 0xB0 removes the highest-priority in-service source. `irq_out` is then set if the top raised source outranks the new top in-service source, or if nothing remains in service.
- R10: A read of 0x90 returns the `CPU_ID` parameter, and a read of 0xB0 returns 0. Writes to 0x90 and 0xA0 have no effect.
- R11: After reset `irq_out` is low and both vectors are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| raise_valid | input | 1 | Controller offers a source to this processor |
| raise_id | input | IDX_W | Index of the offered source |
| src_prio | input | NSRC*PRIO_W | Per-source priority, source k at bits k*PRIO_W |
| src_vec | input | NSRC*VEC_W | Per-source vector number |
| src_sense | input | NSRC | Per-source sense, 1 = level, 0 = edge |
| src_active | input | NSRC | Per-source activity bit |
| spurious_vec | input | VEC_W | Vector returned when no valid source is acknowledged |
| reg_addr | input | 8 | Register offset within the processor window |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after `reg_rd` |
| irq_out | output | 1 | Interrupt line to the processor |
| act_set | output | NSRC | One-cycle strobe: set activity of a source |
| act_clr | output | NSRC | One-cycle strobe: clear activity and pending of a source |

## Verification
The `act_set` and `act_clr` strobes are combinational and due in the same cycle as the raise or acknowledge that causes them. `irq_out`, `reg_rdata` and all vector updates are registered and due one clock later. The bench drives each request at a falling edge. It checks the strobes one time unit later, while the request is still applied, and checks the registered results at the next falling edge, after exactly one rising edge. Every later request therefore sees state whose timing is known, so acknowledge results also confirm the raised and in-service contents left by earlier steps.

// File: rtl/irqd_pkg.sv
// Shared constants for the per-CPU interrupt dispatcher.
// Assumes an 8-bit register offset within the processor window.
package irqd_pkg;
    localparam int          ADDR_W  = 8;
    localparam logic [7:0]  OFS_TPR = 8'h80;  // task priority, read/write
    localparam logic [7:0]  OFS_WHO = 8'h90;  // processor identity, read-only
    localparam logic [7:0]  OFS_ACK = 8'hA0;  // acknowledge, read-only
    localparam logic [7:0]  OFS_EOI = 8'hB0;  // end of interrupt, write

    typedef enum logic [2:0] {
        RSEL_TPR, RSEL_WHO, RSEL_ACK, RSEL_EOI, RSEL_NONE
    } rsel_e;

    // Map an offset onto the register it selects.
    function automatic rsel_e decode(input logic [ADDR_W-1:0] a);
        case (a)
            OFS_TPR: return RSEL_TPR;
            OFS_WHO: return RSEL_WHO;
            OFS_ACK: return RSEL_ACK;
            OFS_EOI: return RSEL_EOI;
            default: return RSEL_NONE;
        endcase
    endfunction
endpackage

// File: rtl/irqd_pick.sv
// Argmax tree: finds the requesting source with the highest priority.
// A right branch wins only with a strictly greater priority, so on a tie
// the lowest index is chosen. found=0 means no request is set.
// Assumes N >= 1; unused leaves up to the next power of two are idle.
module irqd_pick #(
    parameter int N  = 8,
    parameter int PW = 4,
    parameter int IW = 3
) (
    input  logic [N-1:0]    req,
    input  logic [N*PW-1:0] prio,
    output logic            found,
    output logic [IW-1:0]   idx,
    output logic [PW-1:0]   best
);
    localparam int LVL = (N > 1) ? $clog2(N) : 0;
    localparam int P   = 1 << LVL;
    localparam int NN  = 2 * P - 1;

    logic          nv [NN];
    logic [PW-1:0] np [NN];
    logic [IW-1:0] ni [NN];

    // Leaves: heap positions P-1 .. 2P-2, left to right by source index.
    for (genvar k = 0; k < P; k++) begin : g_leaf
        if (k < N) begin : g_real
            assign nv[P-1+k] = req[k];
            assign np[P-1+k] = prio[k*PW +: PW];
            assign ni[P-1+k] = IW'(k);
        end else begin : g_pad
            assign nv[P-1+k] = 1'b0;
            assign np[P-1+k] = '0;
            assign ni[P-1+k] = '0;
        end
    end

    // Internal nodes: keep left unless right is valid and strictly higher.
    for (genvar i = 0; i < P - 1; i++) begin : g_node
        logic take_r;
        assign take_r = nv[2*i+2] && (!nv[2*i+1] || (np[2*i+2] > np[2*i+1]));
        assign nv[i]  = nv[2*i+1] || nv[2*i+2];
        assign np[i]  = take_r ? np[2*i+2] : np[2*i+1];
        assign ni[i]  = take_r ? ni[2*i+2] : ni[2*i+1];
    end

    assign found = nv[0];
    assign idx   = ni[0];
    assign best  = np[0];
endmodule

// File: rtl/irqd_tpr.sv
// Task-priority register: holds the threshold that raises must exceed.
// Loads RESET_VAL on synchronous active-low reset.
module irqd_tpr #(
    parameter int              PW        = 4,
    parameter logic [PW-1:0]   RESET_VAL = '1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [PW-1:0] wdata,
    output logic [PW-1:0] tpr
);
    // Reset to the most restrictive threshold, load on write.
    always_ff @(posedge clk) begin
        if (!rst_n)  tpr <= RESET_VAL;
        else if (we) tpr <= wdata;
    end
endmodule

// File: rtl/cpu_irq_dispatch.sv
// Per-CPU dispatcher: keeps raised and in-service vectors, gates raises
// against task priority, drives the interrupt line, and serves the
// task-priority, identity, acknowledge and end-of-interrupt registers.
// Assumes reg_rd and reg_wr are not both asserted, and no raise is offered
// in the same cycle as an acknowledge. Source configuration is external.
module cpu_irq_dispatch
    import irqd_pkg::*;
#(
    parameter int  NSRC   = 8,
    parameter int  PRIO_W = 4,
    parameter int  VEC_W  = 8,
    parameter int  DATA_W = 32,
    parameter int  CPU_ID = 0,
    localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    raise_valid,
    input  logic [IDX_W-1:0]        raise_id,
    input  logic [NSRC*PRIO_W-1:0]  src_prio,
    input  logic [NSRC*VEC_W-1:0]   src_vec,
    input  logic [NSRC-1:0]         src_sense,
    input  logic [NSRC-1:0]         src_active,
    input  logic [VEC_W-1:0]        spurious_vec,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic                    reg_wr,
    input  logic                    reg_rd,
    input  logic [DATA_W-1:0]       reg_wdata,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic                    irq_out,
    output logic [NSRC-1:0]         act_set,
    output logic [NSRC-1:0]         act_clr
);
    localparam logic [NSRC-1:0] ONE = NSRC'(1);

    logic [NSRC-1:0]   raised_q, inserv_q, inserv_less;
    logic [PRIO_W-1:0] tpr_q;
    rsel_e             sel;
    logic              ack_rd, eoi_wr, tpr_we;

    logic              r_found, s_found, s2_found;
    logic [IDX_W-1:0]  r_idx, s_idx, s2_idx;
    logic [PRIO_W-1:0] r_best, s_best, s2_best;

    logic              raise_ok, ack_ok, requeue;
    logic [PRIO_W-1:0] raise_prio;
    logic [VEC_W-1:0]  ack_vec;
    logic [NSRC-1:0]   set_mask, ack_mask, eoi_mask;

    // Register decode.
    assign sel    = decode(reg_addr);
    assign ack_rd = reg_rd && (sel == RSEL_ACK);
    assign eoi_wr = reg_wr && (sel == RSEL_EOI);
    assign tpr_we = reg_wr && (sel == RSEL_TPR);

    irqd_tpr #(.PW(PRIO_W), .RESET_VAL('1)) u_tpr (
        .clk(clk), .rst_n(rst_n), .we(tpr_we),
        .wdata(reg_wdata[PRIO_W-1:0]), .tpr(tpr_q)
    );

    // Top raised source, top in-service source, and top in-service after EOI.
    irqd_pick #(.N(NSRC), .PW(PRIO_W), .IW(IDX_W)) u_pick_raised (
        .req(raised_q), .prio(src_prio), .found(r_found), .idx(r_idx), .best(r_best)
    );
    irqd_pick #(.N(NSRC), .PW(PRIO_W), .IW(IDX_W)) u_pick_inserv (
        .req(inserv_q), .prio(src_prio), .found(s_found), .idx(s_idx), .best(s_best)
    );
    assign inserv_less = s_found ? (inserv_q & ~(ONE << s_idx)) : inserv_q;
    irqd_pick #(.N(NSRC), .PW(PRIO_W), .IW(IDX_W)) u_pick_after (
        .req(inserv_less), .prio(src_prio), .found(s2_found), .idx(s2_idx), .best(s2_best)
    );

    // Raise qualification: in range, above task priority, not yet raised.
    assign raise_prio = src_prio[raise_id*PRIO_W +: PRIO_W];
    assign raise_ok   = raise_valid && (int'(raise_id) < NSRC) &&
                        (raise_prio > tpr_q) && !raised_q[raise_id];
    assign set_mask   = raise_ok ? (ONE << raise_id) : '0;

    // Acknowledge re-check of the selected source.
    assign ack_ok   = r_found && src_active[r_idx] && (r_best > tpr_q);
    assign ack_vec  = ack_ok ? src_vec[r_idx*VEC_W +: VEC_W] : spurious_vec;
    assign ack_mask = (ack_rd && r_found) ? (ONE << r_idx) : '0;
    assign eoi_mask = (eoi_wr && s_found) ? (ONE << s_idx) : '0;

    // Queued source outranks what remains in service after EOI.
    assign requeue = eoi_wr && r_found && (!s2_found || (r_best > s2_best));

    // Activity strobes to the source storage.
    assign act_set = set_mask;
    assign act_clr = (ack_rd && r_found && (!ack_ok || !src_sense[r_idx])) ? ack_mask : '0;

    // Raised and in-service vectors.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            raised_q <= '0;
            inserv_q <= '0;
        end else begin
            raised_q <= (raised_q | set_mask) & ~ack_mask;
            inserv_q <= (inserv_q | ((ack_rd && ack_ok) ? ack_mask : '0)) & ~eoi_mask;
        end
    end

    // Interrupt line: set by accepted raise or requeue, dropped by acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n)                   irq_out <= 1'b0;
        else if (raise_ok || requeue) irq_out <= 1'b1;
        else if (ack_rd)              irq_out <= 1'b0;
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n) reg_rdata <= '0;
        else if (reg_rd) begin
            case (sel)
                RSEL_TPR: reg_rdata <= DATA_W'(tpr_q);
                RSEL_WHO: reg_rdata <= DATA_W'(CPU_ID);
                RSEL_ACK: reg_rdata <= DATA_W'(ack_vec);
                default:  reg_rdata <= '0;
            endcase
        end
    end
endmodule

// File: rtl/irqd_checker.sv
// Property checker for cpu_irq_dispatch, attached by bind below.
// Observes ports plus the raised vector, task priority and raised pick.
module irqd_checker
    import irqd_pkg::*;
#(
    parameter int NSRC   = 8,
    parameter int PRIO_W = 4,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   raise_valid,
    input logic [IDX_W-1:0]       raise_id,
    input logic [NSRC*PRIO_W-1:0] src_prio,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic                   reg_wr,
    input logic                   reg_rd,
    input logic [DATA_W-1:0]      reg_wdata,
    input logic                   irq_out,
    input logic [NSRC-1:0]        act_set,
    input logic [NSRC-1:0]        act_clr,
    input logic [NSRC-1:0]        raised_q,
    input logic [PRIO_W-1:0]      tpr_q,
    input logic                   r_found,
    input logic [IDX_W-1:0]       r_idx
);
    logic is_ack;
    assign is_ack = reg_rd && (reg_addr == OFS_ACK);

    // R4: a task-priority write lands in the low bits.
    a_r4_tpr_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == OFS_TPR) |=> (tpr_q == $past(reg_wdata[PRIO_W-1:0])));

    // R2: a low-priority offer leaves the raised bit untouched.
    a_r2_low_prio_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (raise_valid && !is_ack && int'(raise_id) < NSRC &&
         src_prio[raise_id*PRIO_W +: PRIO_W] <= tpr_q)
        |=> (raised_q[$past(raise_id)] == $past(raised_q[raise_id])));

    // R5: a set strobe is followed by the line high.
    a_r5_raise_line: assert property (@(posedge clk) disable iff (!rst_n)
        (act_set != '0) |=> irq_out);

    // R5/R8: strobes name at most one source.
    a_r8_strobe_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_set) && $onehot0(act_clr));

    // R6: an acknowledge without a competing raise lowers the line.
    a_r6_ack_lowers: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ack && !reg_wr && act_set == '0) |=> !irq_out);

    // R8: the acknowledged source leaves the raised vector.
    a_r8_ack_retires: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ack && r_found && !raise_valid) |=> !raised_q[$past(r_idx)]);
endmodule

bind cpu_irq_dispatch irqd_checker #(
    .NSRC(NSRC), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
) u_irqd_checker (
    .clk(clk), .rst_n(rst_n), .raise_valid(raise_valid), .raise_id(raise_id),
    .src_prio(src_prio), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .irq_out(irq_out), .act_set(act_set), .act_clr(act_clr),
    .raised_q(raised_q), .tpr_q(tpr_q), .r_found(r_found), .r_idx(r_idx)
);

// File: tb/tb_cpu_irq_dispatch.sv
// Bench: directed corners then seeded random traffic against a bench model.
module tb_cpu_irq_dispatch;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC = 8;
    localparam int PW   = 4;
    localparam int VW   = 8;
    localparam int DW   = 32;
    localparam int IW   = 3;
    localparam int MYID = 5;
    localparam logic [7:0] SPUR = 8'hFF;

    logic clk = 1'b0;
    logic rst_n;
    logic raise_valid;
    logic [IW-1:0] raise_id;
    logic [NSRC*PW-1:0] src_prio;
    logic [NSRC*VW-1:0] src_vec;
    logic [NSRC-1:0] src_sense, src_active;
    logic [7:0] reg_addr;
    logic reg_wr, reg_rd;
    logic [DW-1:0] reg_wdata, reg_rdata;
    logic irq_out;
    logic [NSRC-1:0] act_set, act_clr;

    // Bench model state.
    logic [3:0] m_prio [NSRC];
    logic [7:0] m_vec  [NSRC];
    logic       m_sense[NSRC];
    logic       m_act  [NSRC];
    logic       m_raised[NSRC];
    logic       m_inserv[NSRC];
    logic [3:0] m_tpr;
    logic       m_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack model configuration onto the source inputs.
    always_comb begin
        for (int k = 0; k < NSRC; k++) begin
            src_prio[k*PW +: PW] = m_prio[k];
            src_vec[k*VW +: VW]  = m_vec[k];
            src_sense[k]         = m_sense[k];
            src_active[k]        = m_act[k];
        end
    end

    cpu_irq_dispatch #(.NSRC(NSRC), .PRIO_W(PW), .VEC_W(VW), .DATA_W(DW), .CPU_ID(MYID)) dut (
        .clk(clk), .rst_n(rst_n), .raise_valid(raise_valid), .raise_id(raise_id),
        .src_prio(src_prio), .src_vec(src_vec), .src_sense(src_sense),
        .src_active(src_active), .spurious_vec(SPUR), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .act_set(act_set), .act_clr(act_clr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    // Highest priority, lowest index on tie; -1 when empty.
    function automatic int pick_raised();
        int b = -1;
        for (int i = 0; i < NSRC; i++)
            if (m_raised[i] && (b < 0 || m_prio[i] > m_prio[b])) b = i;
        return b;
    endfunction

    function automatic int pick_inserv();
        int b = -1;
        for (int i = 0; i < NSRC; i++)
            if (m_inserv[i] && (b < 0 || m_prio[i] > m_prio[b])) b = i;
        return b;
    endfunction

    task automatic idle_inputs();
        raise_valid = 0; raise_id = '0; reg_wr = 0; reg_rd = 0;
        reg_addr = 8'h00; reg_wdata = '0;
    endtask

    // Offer a source (R2, R3, R5).
    task automatic t_raise(input int id);
        logic ok;
        ok = (m_prio[id] > m_tpr) && !m_raised[id];
        raise_valid = 1; raise_id = IW'(id);
        #1;
        check(ok ? "R5 act_set" : (m_raised[id] ? "R3 act_set" : "R2 act_set"),
              32'(act_set), ok ? 32'(1 << id) : 32'h0);
        @(negedge clk);
        idle_inputs();
        if (ok) begin m_raised[id] = 1; m_act[id] = 1; m_irq = 1; end
        check(ok ? "R5 irq_out" : "R2 irq_out", 32'(irq_out), 32'(m_irq));
    endtask

    // Acknowledge (R1, R6, R7, R8).
    task automatic t_ack();
        int s; logic ok; logic [7:0] ev; logic [NSRC-1:0] ec;
        s = pick_raised();
        ec = '0;
        if (s < 0) begin ok = 0; ev = SPUR; end
        else begin
            ok = m_act[s] && (m_prio[s] > m_tpr);
            ev = ok ? m_vec[s] : SPUR;
            if (!ok || !m_sense[s]) ec[s] = 1'b1;
        end
        reg_rd = 1; reg_addr = 8'hA0;
        #1;
        check(s < 0 ? "R6 act_clr" : "R8 act_clr", 32'(act_clr), 32'(ec));
        @(negedge clk);
        idle_inputs();
        if (s >= 0) begin
            m_raised[s] = 0;
            if (ok) m_inserv[s] = 1;
            if (ec[s]) m_act[s] = 0;
        end
        m_irq = 0;
        check(s < 0 ? "R6 vector" : (ok ? "R1 vector" : "R7 vector"), reg_rdata, 32'(ev));
        check("R6 irq_out", 32'(irq_out), 32'(m_irq));
    endtask

    // End of interrupt (R9).
    task automatic t_eoi();
        int s, s2, r;
        s = pick_inserv();
        reg_wr = 1; reg_addr = 8'hB0; reg_wdata = 32'h0;
        @(negedge clk);
        idle_inputs();
        if (s >= 0) m_inserv[s] = 0;
        s2 = pick_inserv();
        r = pick_raised();
        if (r >= 0 && (s2 < 0 || m_prio[r] > m_prio[s2])) m_irq = 1;
        check("R9 irq_out", 32'(irq_out), 32'(m_irq));
    endtask

    task automatic t_write(input logic [7:0] a, input logic [31:0] d);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        idle_inputs();
        if (a == 8'h80) m_tpr = d[3:0];
    endtask

    task automatic t_read(input logic [7:0] a, input string req);
        logic [31:0] e;
        e = (a == 8'h80) ? 32'(m_tpr) : (a == 8'h90) ? 32'(MYID) : 32'h0;
        reg_rd = 1; reg_addr = a;
        @(negedge clk);
        idle_inputs();
        check(req, reg_rdata, e);
    endtask

    task automatic set_src(input int k, input logic [3:0] p, input logic [7:0] v, input logic s);
        m_prio[k] = p; m_vec[k] = v; m_sense[k] = s;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        idle_inputs();
        for (int k = 0; k < NSRC; k++) begin
            set_src(k, 4'(k + 1), 8'(8'h40 + k), 1'b0);
            m_act[k] = 0; m_raised[k] = 0; m_inserv[k] = 0;
        end
        m_tpr = 4'hF; m_irq = 0;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R11 / R4: reset state.
        check("R11 irq_out reset", 32'(irq_out), 32'h0);
        t_read(8'h80, "R4 tpr reset");
        t_ack();                          // R11: empty vectors give spurious
        t_read(8'h90, "R10 identity");
        t_read(8'hB0, "R10 eoi read");

        // R4: only low bits stored.
        t_write(8'h80, 32'hFFFF_FFF3);
        t_read(8'h80, "R4 tpr masked");

        // R2: priority equal to threshold dropped.
        set_src(2, 4'd3, 8'h22, 1'b0);
        t_raise(2);
        // R1: tie between 2 and 5, lowest index wins.
        set_src(2, 4'd7, 8'h22, 1'b0);
        set_src(5, 4'd7, 8'h55, 1'b1);
        t_raise(5);
        t_raise(2);
        t_raise(2);                       // R3: already raised
        t_ack();                          // R1: vector 0x22, edge -> act_clr
        t_ack();                          // source 5 level, enters service
        // R10: writes to read-only offsets ignored.
        t_write(8'h90, 32'h0);
        t_write(8'hA0, 32'h0);
        t_read(8'h90, "R10 identity after write");
        t_read(8'h80, "R10 tpr after write");

        // R9: EOI requeues a higher raised source.
        set_src(6, 4'd9, 8'h66, 1'b0);
        t_raise(6);
        t_ack();                          // 6 in service
        set_src(1, 4'd8, 8'h11, 1'b0);
        t_raise(1);
        t_ack();                          // 1: 8 > tpr, acknowledged in service
        t_raise(3);                       // prio 4 > 3
        t_eoi();                          // removes 6; in service 2,5,1 -> top prio 8 > 4: no requeue
        t_eoi();                          // removes 1
        t_eoi();                          // removes 2
        t_eoi();                          // removes 5, nothing left -> requeue
        // R7: threshold raised above a queued source.
        t_write(8'h80, 32'h6);
        t_ack();                          // source 3 prio 4 <= 6: spurious
        t_write(8'h80, 32'h1);
        // R7: level source whose activity dropped.
        set_src(4, 4'd5, 8'h44, 1'b1);
        t_raise(4);
        m_act[4] = 0;
        t_ack();
        for (int k = 0; k < NSRC; k++) t_eoi();

        // Random traffic.
        for (int it = 0; it < 3000; it++) begin
            int r, k;
            r = int'($urandom % 100);
            k = int'($urandom % NSRC);
            if (r < 40)      t_raise(k);
            else if (r < 60) t_ack();
            else if (r < 72) t_eoi();
            else if (r < 80) t_write(8'h80, $urandom % 10);
            else if (r < 85) m_act[k] = 0;
            else if (r < 90) set_src(k, 4'($urandom), 8'($urandom), 1'($urandom));
            else if (r < 95) begin
                case ($urandom % 3)
                    0: t_read(8'h80, "R4 tpr read");
                    1: t_read(8'h90, "R10 identity read");
                    default: t_read(8'hB0, "R10 eoi read");
                endcase
            end else t_write(($urandom % 2) ? 8'h90 : 8'hA0, $urandom);
            check("R5 irq_out level", 32'(irq_out), 32'(m_irq));
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule